// File: doc/BRIEF.md
# Programmable Millisecond Tick Timer

This block raises a periodic interrupt whose period is a whole number of milliseconds. Software programs a reload value `N` through a small register bus, and the timer then raises its interrupt every `N+1` milliseconds. A free-running prescaler turns the system clock into a millisecond strobe. The prescaler's length is set by the parameter `CLKS_PER_MS`, so the same block serves any clock frequency.

The interrupt is a level. Once raised it stays high until software acknowledges it. There are two ways to do that:
- read the count register, which always returns zero;
- write a new reload value.

Writing the reload register also restarts the current period from zero. Periods follow each other back to back: the next period starts in the cycle the previous one ends, whether or not software has acknowledged yet.

Top module: `tick_timer`

## Requirements
- R1: After reset the interrupt is low and the reload register reads 0. The first interrupt rises exactly `CLKS_PER_MS` clock edges after reset is released (a 1 ms period).
- R2: With reload value N, the interrupt rises exactly `CLKS_PER_MS*(N+1)` clock edges after the edge that wrote N.
- R3: When a period expires the interrupt is set, and the next period starts at once. The next expiry therefore comes exactly one period later, independent of when the acknowledge happens.
- R4: A read at word offset 0x230 (the count register) returns zero. It clears the interrupt at the edge that samples the read.
- R5: A write at word offset 0x228 (the reload register) clears a pending interrupt and restarts the period from zero at the edge that samples the write.
- R6: If a period expires at the same edge as an acknowledge, the interrupt stays high.
- R7: A read at word offset 0x228 returns the stored reload value. A write keeps only the low `RELOAD_W` bits of the data (bits [RELOAD_W-1:0]); higher bits are dropped.
- R8: Address bits [1:0] are ignored when decoding. Accesses to any other word offset behave as follows:
  - reads return zero;
  - writes have no effect on the interrupt, the timing or the reload value.
- R9: While no acknowledge arrives, the interrupt stays high across later period expiries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read strobe |
| tick_irq | output | 1 | Level timer interrupt |

## Verification
The bench aims an acknowledge read at the exact edge where a period expires. A design that lets the acknowledge win would drop that tick and show the interrupt low there.

It acknowledges at varying points and then measures the next rise against the previous one. A design that restarted the period on the acknowledge, rather than on the expiry, would land late. It writes the reload register shortly before a pending expiry. A design that did not restart on the write would show an extra, unexpected rise.

It also sends accesses with nonzero low address bits and to unmapped offsets. A sloppy decode would then ack, restart or corrupt the reload value where it must not.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   // which register a decoded bus access targets
   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_RELOAD = 2'd1,
      SEL_COUNT  = 2'd2
   } tick_sel_e;

   // word index of a byte address (drops the two lane bits)
   function automatic logic [29:0] word_of(input logic [31:0] byte_addr);
      return byte_addr[31:2];
   endfunction

endpackage

// File: rtl/tick_reg_decode.sv
module tick_reg_decode
   import tick_timer_pkg::*;
#(
   parameter int unsigned ADDR_W     = 14,
   parameter logic [31:0] RELOAD_OFS = 32'h228,
   parameter logic [31:0] COUNT_OFS  = 32'h230
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output tick_sel_e         sel,
   output logic              reload_wr,
   output logic              count_rd
);
   localparam logic [29:0] RELOAD_WORD = word_of(RELOAD_OFS);
   localparam logic [29:0] COUNT_WORD  = word_of(COUNT_OFS);

   logic [29:0] addr_word;
   logic        lane_unused;

   assign addr_word   = word_of(32'(bus_addr));
   assign lane_unused = ^bus_addr[1:0];

   always_comb begin
      if (addr_word == RELOAD_WORD)     sel = SEL_RELOAD;
      else if (addr_word == COUNT_WORD) sel = SEL_COUNT;
      else                              sel = SEL_NONE;
   end

   assign reload_wr = bus_sel &&  bus_wr && (sel == SEL_RELOAD);
   assign count_rd  = bus_sel && !bus_wr && (sel == SEL_COUNT);

   // R8: a write strobe to an address outside the reload word never restarts
   p_decode_scope_r8: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && bus_wr && (addr_word != RELOAD_WORD)) |-> !reload_wr);

endmodule

// File: rtl/tick_ms_prescaler.sv
module tick_ms_prescaler #(
   parameter int unsigned CLKS_PER_MS = 100000
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic ms_tick
);
   generate
      if (CLKS_PER_MS == 1) begin : g_bypass
         // every clock is a millisecond
         assign ms_tick = 1'b1;
      end else begin : g_div
         localparam int unsigned CW = $clog2(CLKS_PER_MS);
         localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

         logic [CW-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (rst || restart)     pre_q <= '0;
            else if (pre_q == LAST) pre_q <= '0;
            else                    pre_q <= pre_q + 1'b1;
         end

         assign ms_tick = (pre_q == LAST);

         // R2: the prescaler never counts past one millisecond
         p_pre_bound_r2: assert property (@(posedge clk) disable iff (rst)
            pre_q <= LAST);
         // R5: a restart brings the prescaler back to zero
         p_pre_restart_r5: assert property (@(posedge clk) disable iff (rst)
            restart |=> (pre_q == '0));
      end
   endgenerate
endmodule

// File: rtl/tick_period_counter.sv
module tick_period_counter #(
   parameter int unsigned RELOAD_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                restart,
   input  logic                ms_tick,
   input  logic [RELOAD_W-1:0] reload,
   output logic                expire
);
   logic [RELOAD_W-1:0] ms_q;
   logic                at_end;

   assign at_end = (ms_q == reload);

   always_ff @(posedge clk) begin
      if (rst || restart) ms_q <= '0;
      else if (ms_tick)   ms_q <= at_end ? '0 : ms_q + 1'b1;
   end

   assign expire = ms_tick && at_end && !restart;

   // R2: the millisecond count stays within the programmed period
   p_ms_bound_r2: assert property (@(posedge clk) disable iff (rst)
      ms_q <= reload);
   // R3: an expiry starts the next period from zero at once
   p_next_period_r3: assert property (@(posedge clk) disable iff (rst)
      expire |=> (ms_q == '0));
   // R5: a restart clears the millisecond count
   p_ms_restart_r5: assert property (@(posedge clk) disable iff (rst)
      restart |=> (ms_q == '0));
endmodule

// File: rtl/tick_irq_hold.sv
module tick_irq_hold (
   input  logic clk,
   input  logic rst,
   input  logic expire,
   input  logic ack,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (rst)         irq <= 1'b0;
      else if (expire) irq <= 1'b1;
      else if (ack)    irq <= 1'b0;
   end

   // R3: an expiry raises the interrupt
   p_expire_sets_r3: assert property (@(posedge clk) disable iff (rst)
      expire |=> irq);
   // R3: the interrupt only rises after an expiry
   p_rise_cause_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(irq) |-> $past(expire));
   // R4: an acknowledge alone clears the interrupt
   p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
      (ack && !expire) |=> !irq);
   // R6: simultaneous expiry and acknowledge leaves the interrupt high
   p_expire_wins_r6: assert property (@(posedge clk) disable iff (rst)
      (ack && expire) |=> irq);
   // R9: without an acknowledge a raised interrupt holds
   p_level_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (irq && !ack) |=> irq);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int unsigned CLKS_PER_MS = 100000,
   parameter int unsigned ADDR_W      = 14,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned RELOAD_W    = 16,
   parameter logic [31:0] RELOAD_OFS  = 32'h228,
   parameter logic [31:0] COUNT_OFS   = 32'h230
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              tick_irq
);
   // elaboration-time parameter checks
   generate
      if (CLKS_PER_MS < 1) begin : g_chk_clk
         $error("CLKS_PER_MS must be at least 1");
      end
      if (RELOAD_W < 1 || RELOAD_W > DATA_W) begin : g_chk_rw
         $error("RELOAD_W must lie in 1..DATA_W");
      end
      if (ADDR_W < 3 || ADDR_W > 32) begin : g_chk_aw
         $error("ADDR_W must lie in 3..32");
      end
      if (RELOAD_OFS[31:2] == COUNT_OFS[31:2]) begin : g_chk_ofs
         $error("reload and count offsets must be distinct words");
      end
   endgenerate

   tick_sel_e           sel;
   logic                reload_wr;
   logic                count_rd;
   logic                ms_tick;
   logic                expire;
   logic                ack;
   logic [RELOAD_W-1:0] reload_q;
   logic                wdata_unused;

   assign wdata_unused = ^bus_wdata;

   tick_reg_decode #(
      .ADDR_W    (ADDR_W),
      .RELOAD_OFS(RELOAD_OFS),
      .COUNT_OFS (COUNT_OFS)
   ) u_dec (
      .clk      (clk),
      .rst      (rst),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .sel      (sel),
      .reload_wr(reload_wr),
      .count_rd (count_rd)
   );

   always_ff @(posedge clk) begin
      if (rst)            reload_q <= '0;
      else if (reload_wr) reload_q <= bus_wdata[RELOAD_W-1:0];
   end

   tick_ms_prescaler #(.CLKS_PER_MS(CLKS_PER_MS)) u_pre (
      .clk    (clk),
      .rst    (rst),
      .restart(reload_wr),
      .ms_tick(ms_tick)
   );

   tick_period_counter #(.RELOAD_W(RELOAD_W)) u_per (
      .clk    (clk),
      .rst    (rst),
      .restart(reload_wr),
      .ms_tick(ms_tick),
      .reload (reload_q),
      .expire (expire)
   );

   assign ack = count_rd || reload_wr;

   tick_irq_hold u_irq (
      .clk   (clk),
      .rst   (rst),
      .expire(expire),
      .ack   (ack),
      .irq   (tick_irq)
   );

   always_comb begin
      unique case (sel)
         SEL_RELOAD: bus_rdata = DATA_W'(reload_q);
         default:    bus_rdata = '0;
      endcase
   end

   // R4: the count register always reads zero
   p_count_zero_r4: assert property (@(posedge clk) disable iff (rst)
      count_rd |-> (bus_rdata == '0));
   // R5: a reload write drops a pending interrupt
   p_reload_clears_r5: assert property (@(posedge clk) disable iff (rst)
      reload_wr |=> !tick_irq);
   // R7: the reload register takes the low bits of the write data
   p_reload_store_r7: assert property (@(posedge clk) disable iff (rst)
      reload_wr |=> (reload_q == $past(bus_wdata[RELOAD_W-1:0])));
   // R8: unrelated accesses leave the reload value alone
   p_reload_keep_r8: assert property (@(posedge clk) disable iff (rst)
      !reload_wr |=> $stable(reload_q));
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
   localparam int C  = 4;
   localparam int AW = 14;
   localparam logic [AW-1:0] A_RELOAD = 14'h228;
   localparam logic [AW-1:0] A_COUNT  = 14'h230;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          tick_irq;

   always #5 clk = ~clk;

   tick_timer #(.CLKS_PER_MS(C)) u0 (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .tick_irq(tick_irq)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;
   int exp_q[$];
   logic irq_prev = 1'b0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // monitor: every interrupt rise is compared with the scoreboard head
   always @(negedge clk) begin
      int e;
      if (!rst) begin
         if (tick_irq && !irq_prev) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected rise at cycle", cyc, -1);
            else begin
               e = exp_q.pop_front();
               chk(cyc == e, "R2 rise cycle", cyc, e);
            end
         end
         irq_prev = tick_irq;
      end
   end

   task automatic write_reg(input logic [AW-1:0] a, input logic [31:0] d, output int wedge);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      wedge = cyc + 1;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic read_reg(input logic [AW-1:0] a, output logic [31:0] d, output int redge);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      redge = cyc + 1;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic wait_rise(output int r);
      @(negedge clk);
      while (!tick_irq) @(negedge clk);
      r = cyc;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      int e, r, w, x, y;
      // R1: reset state and first 1 ms period
      repeat (3) @(negedge clk);
      chk(tick_irq == 1'b0, "R1 irq low in reset", tick_irq, 0);
      rst = 1'b0;
      exp_q.push_back(cyc + C);
      read_reg(A_RELOAD, d, e);
      chk(d == 0, "R1 reload reads zero after reset", d, 0);
      chk(tick_irq == 1'b0, "R1 irq low after reset", tick_irq, 0);
      wait_rise(r);
      exp_q.push_back(r + C);                  // R3 back-to-back period
      read_reg(A_COUNT, d, e);
      chk(d == 0, "R4 count reads zero", d, 0);
      chk(tick_irq == 1'b0, "R4 read clears irq", tick_irq, 0);
      wait_rise(r);
      read_reg(A_COUNT, d, e);
      chk(tick_irq == 1'b0, "R4 second ack clears", tick_irq, 0);

      // R5/R7: reload write before the pending expiry restarts the period
      write_reg(A_RELOAD, 32'hABCD_0005, w);
      exp_q.push_back(w + C * 6);
      chk(tick_irq == 1'b0, "R5 irq low after reload write", tick_irq, 0);
      read_reg(A_RELOAD, d, e);
      chk(d == 32'h5, "R7 upper bits dropped", d, 5);
      wait_rise(r);
      repeat (30) @(negedge clk);
      chk(tick_irq == 1'b1, "R9 irq held across expiry", tick_irq, 1);
      write_reg(A_RELOAD, 32'h3, w);
      chk(tick_irq == 1'b0, "R5 write clears pending irq", tick_irq, 0);
      exp_q.push_back(w + C * 4);

      // R6: acknowledge lands on the expiry edge
      wait_rise(x);
      while (cyc < x + 14) @(negedge clk);
      read_reg(A_COUNT, d, e);
      chk(e == x + 16, "R6 ack aligned to expiry", e, x + 16);
      chk(tick_irq == 1'b1, "R6 expiry wins over ack", tick_irq, 1);
      read_reg(A_COUNT, d, e);
      chk(tick_irq == 1'b0, "R6 later ack clears", tick_irq, 0);
      exp_q.push_back(x + 32);

      // R8: unmapped offsets and lane bits
      wait_rise(y);
      write_reg(14'h100, 32'hFFFF_FFFF, w);
      chk(tick_irq == 1'b1, "R8 unmapped write keeps irq", tick_irq, 1);
      read_reg(14'h100, d, e);
      chk(d == 0, "R8 unmapped read zero", d, 0);
      chk(tick_irq == 1'b1, "R8 unmapped read no ack", tick_irq, 1);
      read_reg(A_RELOAD, d, e);
      chk(d == 3, "R8 reload unchanged", d, 3);
      read_reg(14'h231, d, e);
      chk(d == 0, "R8 count via lane address reads zero", d, 0);
      chk(tick_irq == 1'b0, "R8 lane address acks", tick_irq, 0);
      write_reg(14'h22A, 32'h1, w);
      exp_q.push_back(w + C * 2);
      read_reg(14'h229, d, e);
      chk(d == 1, "R7 reload via lane address", d, 1);
      wait_rise(r);
      read_reg(A_COUNT, d, e);
      chk(tick_irq == 1'b0, "R4 final ack", tick_irq, 0);
      chk(exp_q.size() == 0, "R2 all expected rises seen", exp_q.size(), 0);
      summary();
      $finish;
   end
endmodule